// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one read or write column command into the column address of every beat of the burst that follows it. A start strobe loads a 10-bit start column together with the burst-length code and the ordering bit that the mode register currently holds. From the next cycle on, the block presents one column address per clock cycle, along with a flag that marks the beat as valid and a flag that marks the final beat of a bounded burst.

Fixed-length bursts stay inside a block of burst-length columns, aligned to that length. Within that block the address walks either in ascending order with wrap-around or in an order formed by XOR with the beat index. The full-page length runs through the whole 1024-column page, wraps from the top column to column 0, and never ends by itself. A burst-stop input, or a new start, ends any burst. Because a column command may arrive on any cycle, a new start always takes over from the running burst.

Top module: `sdram_colgen`

## Requirements
- R1: While reset is high and in the first cycle after it is released, beat_valid_o and last_o are low, whatever the start input was during reset.
- R2: When start_i is high at a clock edge, in the following cycle beat_valid_o is high and col_o equals the sampled start_col_i (beat 0).
- R3: The burst-length code gives the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The codes 3'b100, 3'b101 and 3'b110 behave as length 1. After the last beat of a fixed length, beat_valid_o goes low.
- R4: With burst_order_i = 0 (sequential) and length L in {2,4,8}, beat k has its low log2(L) bits equal to (start + k) mod L, and its upper bits equal to those of the start column.
- R5: With burst_order_i = 1 (interleave) and length L in {2,4,8}, beat k has its low log2(L) bits equal to the start's low bits XOR k, and its upper bits equal to those of the start column.
- R6: In full-page mode beat k is (start + k) mod 1024 whatever burst_order_i is, and the burst continues until a stop or a new start. last_o is never high in this mode.
- R7: last_o is high exactly on beat L-1 of a fixed-length burst, and only while beat_valid_o is high.
- R8: A stop_i sampled high without start_i ends the burst: in the next cycle beat_valid_o and last_o are low. A stop_i while idle has no effect.
- R9: A start_i during a running burst restarts the sequence from the new start column in the next cycle. When start_i and stop_i are high together, the start wins.
- R10: The burst-length code and the ordering bit are captured at start. Changes to them during a burst do not alter that burst's addresses or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Column command strobe; starts a burst |
| start_col_i | input | 10 | Start column address |
| bl_code_i | input | 3 | Burst-length code from the mode register |
| burst_order_i | input | 1 | 0 = sequential ordering, 1 = interleave ordering |
| stop_i | input | 1 | Burst-stop command |
| col_o | output | 10 | Column address of the current beat |
| beat_valid_o | output | 1 | High while a beat is being presented |
| last_o | output | 1 | High on the final beat of a fixed-length burst |

## Verification
The bench builds the block with its default 10-bit column and 3-bit code, so the full-page wrap from column 1023 back to 0 can be reached within a few hundred cycles. Directed bursts start at columns near the top of the page and at odd low bits, so both orderings wrap inside their aligned block. They also cover every reserved code, and they collide start with stop and change the mode inputs in mid-burst. Seeded random bursts of all codes, interrupted by random stops and restarts, are compared cycle by cycle against a bench model of the beat sequence.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

    localparam int COL_W     = 10;
    localparam int CODE_W    = 3;
    localparam int PAGE_COLS = 1 << COL_W;

    localparam logic [CODE_W-1:0] BLC_1    = 3'b000;
    localparam logic [CODE_W-1:0] BLC_2    = 3'b001;
    localparam logic [CODE_W-1:0] BLC_4    = 3'b010;
    localparam logic [CODE_W-1:0] BLC_8    = 3'b011;
    localparam logic [CODE_W-1:0] BLC_PAGE = 3'b111;

    typedef logic [COL_W-1:0]  col_t;
    typedef logic [CODE_W-1:0] blcode_t;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    // Captured burst configuration: the wrap mask covers the bits that move.
    typedef struct packed {
        col_t   mask;
        logic   page;
        order_e order;
    } burst_cfg_t;

    typedef struct packed {
        logic       active;
        col_t       beat;
        col_t       base;
        burst_cfg_t cfg;
    } burst_state_t;

    // Mask of the low column bits that wrap for a given length code.
    function automatic col_t len_mask(input blcode_t code);
        col_t m;
        case (code)
            BLC_2:    m = col_t'(1);
            BLC_4:    m = col_t'(3);
            BLC_8:    m = col_t'(7);
            BLC_PAGE: m = '1;
            default:  m = '0;
        endcase
        return m;
    endfunction

    function automatic burst_cfg_t decode_cfg(input blcode_t code, input logic ilv);
        burst_cfg_t c;
        c.mask  = len_mask(code);
        c.page  = (code == BLC_PAGE);
        c.order = (c.page || !ilv) ? ORD_SEQ : ORD_ILV;
        return c;
    endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import sdram_colgen_pkg::*;
(
    input  blcode_t    code_i,
    input  logic       ilv_i,
    output burst_cfg_t cfg_o
);

    always_comb begin
        cfg_o = decode_cfg(code_i, ilv_i);
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import sdram_colgen_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         stop_i,
    input  col_t         start_col_i,
    input  burst_cfg_t   cfg_i,
    output burst_state_t st_o
);

    burst_state_t st_q;
    burst_state_t st_d;
    logic         at_end;

    // A bounded burst ends once the beat index has reached the wrap mask.
    assign at_end = !st_q.cfg.page && (st_q.beat == st_q.cfg.mask);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.beat   = '0;
            st_d.base   = start_col_i;
            st_d.cfg    = cfg_i;
        end else if (stop_i) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            if (at_end) begin
                st_d.active = 1'b0;
            end else begin
                st_d.beat = st_q.beat + col_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
    import sdram_colgen_pkg::*;
(
    input  burst_state_t st_i,
    output col_t         col_o,
    output logic         valid_o,
    output logic         last_o
);

    col_t seq_addr;
    col_t ilv_addr;
    col_t moving;

    assign seq_addr = st_i.base + st_i.beat;
    assign ilv_addr = st_i.base ^ st_i.beat;
    assign moving   = (st_i.cfg.order == ORD_ILV) ? ilv_addr : seq_addr;

    // Bits under the mask follow the ordering; the others keep the start column.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = st_i.cfg.mask[b] ? moving[b] : st_i.base[b];
    end

    assign valid_o = st_i.active;
    assign last_o  = st_i.active && !st_i.cfg.page && (st_i.beat == st_i.cfg.mask);

endmodule

// File: rtl/sdram_colgen.sv
module sdram_colgen
    import sdram_colgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] bl_code_i,
    input  logic              burst_order_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              beat_valid_o,
    output logic              last_o
);

    burst_cfg_t   cfg_new;
    burst_state_t st;

    burst_cfg_decode u_dec (
        .code_i (bl_code_i),
        .ilv_i  (burst_order_i),
        .cfg_o  (cfg_new)
    );

    burst_beat_ctr u_ctr (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .start_col_i (start_col_i),
        .cfg_i       (cfg_new),
        .st_o        (st)
    );

    burst_col_map u_map (
        .st_i    (st),
        .col_o   (col_o),
        .valid_o (beat_valid_o),
        .last_o  (last_o)
    );

endmodule

// File: rtl/sdram_colgen_chk.sv
module sdram_colgen_chk
    import sdram_colgen_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [COL_W-1:0]  start_col_i,
    input logic [CODE_W-1:0] bl_code_i,
    input logic              stop_i,
    input logic [COL_W-1:0]  col_o,
    input logic              beat_valid_o,
    input logic              last_o
);

    col_t mask_q;
    logic page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            page_q <= 1'b0;
        end else if (start_i) begin
            mask_q <= len_mask(bl_code_i);
            page_q <= (bl_code_i == BLC_PAGE);
        end
    end

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!beat_valid_o && !last_o));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (beat_valid_o && col_o == $past(start_col_i)));

    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        last_o |-> beat_valid_o);

    // R3
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !beat_valid_o);

    // R8
    stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !start_i) |=> (!beat_valid_o && !last_o));

    // R4
    upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && !last_o && !start_i && !stop_i) |=>
            (beat_valid_o && ((col_o & ~mask_q) == ($past(col_o) & ~mask_q))));

    // R6
    page_step_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && page_q && !start_i && !stop_i) |=>
            (beat_valid_o && !last_o && col_o == $past(col_o) + col_t'(1)));

endmodule

bind sdram_colgen sdram_colgen_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .start_col_i  (start_col_i),
    .bl_code_i    (bl_code_i),
    .stop_i       (stop_i),
    .col_o        (col_o),
    .beat_valid_o (beat_valid_o),
    .last_o       (last_o)
);

// File: tb/sdram_colgen_bench.sv
module sdram_colgen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [9:0] start_col_i = '0;
    logic [2:0] bl_code_i = '0;
    logic       burst_order_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [9:0] col_o;
    logic       beat_valid_o;
    logic       last_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // bench model of the beat sequence
    bit m_active = 0;
    int m_k = 0, m_base = 0, m_len = 1;
    bit m_ilv = 0;

    always #2 clk = ~clk;

    sdram_colgen u_sdram_colgen (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .bl_code_i(bl_code_i), .burst_order_i(burst_order_i), .stop_i(stop_i),
        .col_o(col_o), .beat_valid_o(beat_valid_o), .last_o(last_o)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            summary();
        end
    end

    // R3: number of beats for a code; 0 stands for full page
    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int base, input int k, input int len, input bit ilv);
        int m, low;
        if (len == 0) return (base + k) % 1024;
        m = len - 1;
        low = ilv ? ((base ^ k) & m) : ((base + k) & m);
        return (base & ~m & 1023) | low;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        bit exp_last;
        exp_last = m_active && (m_len != 0) && (m_k == m_len - 1);
        check(tag, "valid", int'(beat_valid_o), int'(m_active));
        check(tag, "last", int'(last_o), int'(exp_last));
        if (m_active)
            check(tag, "col", int'(col_o), exp_col(m_base, m_k, m_len, m_ilv));
    endtask

    // Called at a negedge: compare, drive, take one clock edge, update the model.
    task automatic step(input string tag, input bit s, input bit p,
                        input int c, input logic [2:0] code, input bit o);
        compare(tag);
        start_i = s; stop_i = p; start_col_i = 10'(c);
        bl_code_i = code; burst_order_i = o;
        @(posedge clk);
        if (s) begin
            m_active = 1; m_k = 0; m_base = c; m_len = len_of(code);
            m_ilv = (len_of(code) == 0) ? 1'b0 : o;
        end else if (p) begin
            m_active = 0;
        end else if (m_active) begin
            if (m_len != 0 && m_k == m_len - 1) m_active = 0;
            else m_k = (m_k + 1) % 1024;
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, bl_code_i, burst_order_i);
    endtask

    initial begin
        int seed;
        seed = 32'h5d17;
        void'($urandom(seed));
        // R1: start held high during reset must be ignored
        start_i = 1'b1; start_col_i = 10'h155; bl_code_i = 3'b111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; start_i = 1'b0;
        m_active = 0;
        compare("R1");
        @(posedge clk);
        @(negedge clk);
        compare("R1");

        // R2 R4: sequential length 4 from 0x3FE wraps inside its block
        step("R2", 1, 0, 'h3FE, 3'b010, 0);
        idle("R4", 5);
        // R4: sequential length 8 and 2
        step("R4", 1, 0, 'h2F5, 3'b011, 0);
        idle("R4", 9);
        step("R4", 1, 0, 'h001, 3'b001, 0);
        idle("R4", 3);
        // R5: interleave lengths 8, 4 and 2
        step("R5", 1, 0, 'h0D5, 3'b011, 1);
        idle("R5", 9);
        step("R5", 1, 0, 'h1E6, 3'b010, 1);
        idle("R5", 5);
        step("R5", 1, 0, 'h3FF, 3'b001, 1);
        idle("R5", 3);
        // R3: length 1 and reserved codes
        step("R3", 1, 0, 'h123, 3'b000, 0);
        idle("R3", 2);
        for (int rc = 4; rc < 7; rc++) begin
            step("R3", 1, 0, 'h0F0 + rc, 3'(rc), 1);
            idle("R3", 2);
        end
        // R6: full page wraps from 1023 to 0, interleave bit ignored, never last
        step("R6", 1, 0, 'h3FC, 3'b111, 1);
        idle("R6", 12);
        // R8: stop ends it; a stop while idle does nothing
        step("R8", 0, 1, 0, 3'b111, 0);
        idle("R8", 2);
        step("R8", 0, 1, 0, 3'b011, 0);
        idle("R8", 2);
        // R8: stop in the middle of a length 8 burst
        step("R8", 1, 0, 'h040, 3'b011, 0);
        idle("R8", 2);
        step("R8", 0, 1, 0, 3'b011, 0);
        idle("R8", 2);
        // R9: restart in mid-burst, and start together with stop
        step("R9", 1, 0, 'h200, 3'b011, 0);
        idle("R9", 3);
        step("R9", 1, 0, 'h31B, 3'b010, 1);
        idle("R9", 1);
        step("R9", 1, 1, 'h0AA, 3'b001, 0);
        idle("R9", 3);
        // R7: start on the last beat of a burst continues seamlessly
        step("R7", 1, 0, 'h010, 3'b001, 0);
        step("R7", 0, 0, 0, 3'b001, 0);
        step("R7", 1, 0, 'h155, 3'b010, 1);
        idle("R7", 5);
        // R10: mode inputs change during a burst
        step("R10", 1, 0, 'h0C3, 3'b010, 0);
        step("R10", 0, 0, 0, 3'b111, 1);
        step("R10", 0, 0, 0, 3'b011, 1);
        step("R10", 0, 0, 0, 3'b001, 1);
        idle("R10", 3);
        step("R10", 1, 0, 'h3F0, 3'b111, 0);
        step("R10", 0, 0, 0, 3'b000, 1);
        idle("R10", 20);
        step("R10", 0, 1, 0, 3'b000, 0);
        idle("R10", 2);

        // R3: seeded random bursts of all codes with stops and restarts
        for (int i = 0; i < 3000; i++) begin
            bit s, p;
            s = ($urandom % 7) == 0;
            p = ($urandom % 23) == 0;
            step("R3", s, p, int'($urandom % 1024), 3'($urandom % 8), 1'($urandom % 2));
        end
        compare("R3");
        summary();
    end

endmodule